// File: doc/BRIEF.md
# Butterfly LUT Permuter

This block reshapes a 64-bit word by passing it through a chain of butterfly rows, one row per power-of-two pairing distance (1, 2, 4, 8, 16, 32). Inside an active row, each pair of bits `(l, h)` with `h = l + step` is rewritten through two 4-entry truth tables. One table produces the new value of the lower bit `l` and the other produces the new value of the upper bit `h`. Both tables are addressed by the same two old bits. Because the tables are programmable rather than a fixed swap, the same datapath performs generalised bit reversal, generalised OR-combine, arbitrary mixing, and the generation of many repeating constants from a built-in alternating seed.

Two operating variants are selected per operation:
- **Immediate variant:** a single table byte is used by every row that a shift amount enables.
- **Per-row variant:** every row is active, and each row reads its own table byte from operand B.

A narrow mode restricts the operation to the low 32 bits and to distances 1 to 16. An invert flag complements the starting word. Operands are presented together with a valid strobe, and the result appears one clock later in an output register with its own valid flag.

Top module: `bflut_unit`

## Requirements
- R1: When `src_zero` is 1, the starting word is the alternating constant 0x5555_5555_5555_5555 (even bit positions set). Otherwise the starting word is `src_a`.
- R2: When `inv` is 1, the starting word is complemented before the first row. A zero source with `inv` set therefore starts from 0xAAAA_AAAA_AAAA_AAAA.
- R3: In an active row of distance `step`, each pair `(l, h = l + step)` with `l & step == 0` forms the index `idx = 2*old[l] + old[h]`. The new `l` is table bit `idx` (low nibble, bits 3:0). The new `h` is table bit `4 + idx` (high nibble, bits 7:4).
- R4: In the immediate variant, row k (distance 2^k) is active only when bit k of the shift amount is 1. The shift amount is `src_b[5:0]`. All other bits of `src_b` have no effect. Rows are applied in increasing distance order, each feeding the next.
- R5: Table byte 0xCA makes the immediate variant equal to a generalised reverse, which swaps every pair in each selected row.
- R6: Table byte 0xEE makes the immediate variant equal to a generalised OR-combine, which ORs every pair in each selected row.
- R7: When `per_row` is 1, every row is active, and row i uses `src_b[8i+7:8i]` as its table byte. `tbl_imm` and the shift amount have no effect.
- R8: When `half_mode` is 1, only rows with distances 1 to 16 exist. Only `src_a[31:0]` takes part. The shift amount is `src_b[4:0]`. Result bits 63:32 are 0.
- R9: With a zero source, no invert and table 0x6C, shift amounts 0b10, 0b110 and 0b1110 give 0x1111..., 0x0101... and 0x0001_0001... With a zero source, invert set and table 0xC6, the same shift amounts give 0x8888..., 0x8080... and 0x8000_8000...
- R10: `out_valid` follows `in_valid` with one cycle of latency. `out_data` loads only in a cycle where `in_valid` is 1 and otherwise holds its value. Reset clears both outputs to 0.
- R11: In the immediate variant with a zero shift amount, the result is the starting word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_zero | input | 1 | Use the built-in alternating seed instead of `src_a` |
| src_a | input | 64 | Source word |
| src_b | input | 64 | Shift amount (immediate variant) or per-row table bytes |
| tbl_imm | input | 8 | Table byte for the immediate variant |
| inv | input | 1 | Complement the starting word |
| half_mode | input | 1 | 32-bit operation |
| per_row | input | 1 | Select the per-row table variant |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Registered result |

## Verification
A row that is wrongly enabled, or that reads the wrong nibble, corrupts every pair at that distance. The error is visible at `out_data` on the cycle after the strobe, because no state is carried between operations. Comparing random words against independent generalised-reverse and OR-combine models exposes errors in row order and in pair indexing. The six listed constants pin down the nibble split and the seed. The narrow-mode and hold checks expose leakage into the upper half and registers that load when no strobe is present.

// File: rtl/bflut_pkg.sv
package bflut_pkg;

   typedef enum logic {
      VAR_IMM = 1'b0,
      VAR_ROW = 1'b1
   } bflut_variant_e;

   // Pair lookup: index is {lower-position bit, upper-position bit}
   function automatic logic pair_pick(input logic [3:0] nib,
                                      input logic       lo_bit,
                                      input logic       hi_bit);
      return nib[{lo_bit, hi_bit}];
   endfunction

endpackage

// File: rtl/bflut_seed.sv
module bflut_seed #(
   parameter int DATA_W    = 64,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              src_zero,
   input  logic [DATA_W-1:0] src_a,
   input  logic              inv,
   input  logic              narrow,
   output logic [DATA_W-1:0] seed
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] alt_pat;
   logic [DATA_W-1:0] base_w;
   logic [DATA_W-1:0] flip_w;

   for (genvar g = 0; g < DATA_W; g++) begin : g_alt
      assign alt_pat[g] = ((g % 2) == 0) ? 1'b1 : 1'b0;
   end

   assign base_w = src_zero ? alt_pat : src_a;
   assign flip_w = base_w ^ {DATA_W{inv}};

   if (NARROW_EN) begin : g_narrow
      assign seed = narrow ? {{HALF_W{1'b0}}, flip_w[HALF_W-1:0]} : flip_w;
   end else begin : g_wide
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign seed = flip_w;
   end
endmodule

// File: rtl/bflut_ctl.sv
module bflut_ctl
   import bflut_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter bit NARROW_EN = 1'b1,
   localparam int ROWS     = $clog2(DATA_W)
) (
   input  logic                  per_row,
   input  logic                  narrow,
   input  logic [DATA_W-1:0]     op_b,
   input  logic [7:0]            tbl_imm,
   output logic [ROWS-1:0]       row_en,
   output logic [ROWS-1:0][7:0]  row_tbl
);
   localparam int USED_B = 8 * ROWS;

   bflut_variant_e variant;
   logic           narrow_eff;
   logic [ROWS-1:0] shamt;
   logic [DATA_W-USED_B-1:0] unused_hi;

   assign variant    = per_row ? VAR_ROW : VAR_IMM;
   assign narrow_eff = NARROW_EN ? narrow : 1'b0;
   assign unused_hi  = op_b[DATA_W-1:USED_B];

   always_comb begin
      shamt = op_b[ROWS-1:0];
      if (narrow_eff) shamt[ROWS-1] = 1'b0;
   end

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      logic row_exists;
      if (g == ROWS - 1) begin : g_top
         assign row_exists = ~narrow_eff;
      end else begin : g_low
         assign row_exists = 1'b1;
      end
      always_comb begin
         unique case (variant)
            VAR_ROW: begin
               row_tbl[g] = op_b[8*g +: 8];
               row_en[g]  = row_exists;
            end
            default: begin
               row_tbl[g] = tbl_imm;
               row_en[g]  = shamt[g];
            end
         endcase
      end
   end
endmodule

// File: rtl/bflut_row.sv
module bflut_row
   import bflut_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int STEP   = 1
) (
   input  logic              en,
   input  logic [7:0]        tbl,
   input  logic [DATA_W-1:0] x_in,
   output logic [DATA_W-1:0] x_out
);
   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if ((g & STEP) == 0) begin : g_lo
         assign x_out[g] = en ? pair_pick(tbl[3:0], x_in[g], x_in[g+STEP]) : x_in[g];
      end else begin : g_hi
         assign x_out[g] = en ? pair_pick(tbl[7:4], x_in[g-STEP], x_in[g]) : x_in[g];
      end
   end
endmodule

// File: rtl/bflut_unit.sv
module bflut_unit #(
   parameter int DATA_W    = 64,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              src_zero,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [7:0]        tbl_imm,
   input  logic              inv,
   input  logic              half_mode,
   input  logic              per_row,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int ROWS   = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;

   if ((1 << ROWS) != DATA_W) begin : g_chk_pow2
      $error("bflut_unit: DATA_W must be a power of two");
   end
   if (8 * ROWS >= DATA_W) begin : g_chk_bytes
      $error("bflut_unit: DATA_W too small to hold one table byte per row");
   end

   logic [DATA_W-1:0]          seed;
   logic [ROWS-1:0]            row_en;
   logic [ROWS-1:0][7:0]       row_tbl;
   logic [ROWS:0][DATA_W-1:0]  stage;
   logic [DATA_W-1:0]          result;

   bflut_seed #(.DATA_W(DATA_W), .NARROW_EN(NARROW_EN)) u_seed (
      .src_zero (src_zero),
      .src_a    (src_a),
      .inv      (inv),
      .narrow   (half_mode),
      .seed     (seed)
   );

   bflut_ctl #(.DATA_W(DATA_W), .NARROW_EN(NARROW_EN)) u_ctl (
      .per_row  (per_row),
      .narrow   (half_mode),
      .op_b     (src_b),
      .tbl_imm  (tbl_imm),
      .row_en   (row_en),
      .row_tbl  (row_tbl)
   );

   assign stage[0] = seed;

   for (genvar k = 0; k < ROWS; k++) begin : g_stage
      bflut_row #(.DATA_W(DATA_W), .STEP(1 << k)) u_row (
         .en    (row_en[k]),
         .tbl   (row_tbl[k]),
         .x_in  (stage[k]),
         .x_out (stage[k+1])
      );
   end

   if (NARROW_EN) begin : g_res_narrow
      assign result = half_mode ? {{HALF_W{1'b0}}, stage[ROWS][HALF_W-1:0]} : stage[ROWS];
   end else begin : g_res_wide
      assign result = stage[ROWS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end
endmodule

// File: rtl/bflut_chk.sv
module bflut_chk #(
   parameter int DATA_W    = 64,
   parameter bit NARROW_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              src_zero,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [7:0]        tbl_imm,
   input logic              inv,
   input logic              half_mode,
   input logic              per_row,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);
   localparam int ROWS   = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;

   logic plain_wide;
   assign plain_wide = !per_row && !half_mode && !inv && !src_zero;

   // R10: valid is delayed by exactly one cycle
   assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R10: data holds without a strobe
   assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   // R11: zero shift passes the source through
   assert_zero_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && plain_wide && src_b[ROWS-1:0] == '0) |=> out_data == $past(src_a));

   // R6: OR-combine never clears a source bit
   assert_orc_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && plain_wide && tbl_imm == 8'hEE) |=> (out_data & $past(src_a)) == $past(src_a));

   // R8: narrow results have a clear upper half
   if (NARROW_EN) begin : g_narrow_chk
      assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && half_mode) |=> out_data[DATA_W-1:HALF_W] == '0);
   end

   // R2: inverted zero-source seed with zero shift gives the complement pattern
   assert_inv_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !per_row && !half_mode && inv && src_zero && src_b[ROWS-1:0] == '0)
      |=> $countones(out_data) == HALF_W && out_data[0] == 1'b0);
endmodule

bind bflut_unit bflut_chk #(.DATA_W(DATA_W), .NARROW_EN(NARROW_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .src_zero  (src_zero),
   .src_a     (src_a),
   .src_b     (src_b),
   .tbl_imm   (tbl_imm),
   .inv       (inv),
   .half_mode (half_mode),
   .per_row   (per_row),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/bflut_unit_tb.sv
module bflut_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        src_zero;
   logic [63:0] src_a;
   logic [63:0] src_b;
   logic [7:0]  tbl_imm;
   logic        inv;
   logic        half_mode;
   logic        per_row;
   logic        out_valid;
   logic [63:0] out_data;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bflut_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_zero(src_zero),
      .src_a(src_a), .src_b(src_b), .tbl_imm(tbl_imm), .inv(inv),
      .half_mode(half_mode), .per_row(per_row),
      .out_valid(out_valid), .out_data(out_data)
   );

   // Specification model built from R1-style seed, pair rule and row selection
   function automatic logic [63:0] spec_model(input bit z, input logic [63:0] a,
      input logic [63:0] b, input logic [7:0] t, input bit iv, input bit nw, input bit pr);
      logic [63:0] x, y;
      logic [7:0]  tb;
      bit          act;
      int          nrows;
      x = z ? 64'h5555_5555_5555_5555 : a;
      if (iv) x = ~x;
      if (nw) x[63:32] = '0;
      nrows = nw ? 5 : 6;
      for (int k = 0; k < nrows; k++) begin
         int step = 1 << k;
         tb  = pr ? b[8*k +: 8] : t;
         act = pr ? 1'b1 : b[k];
         if (act) begin
            y = x;
            for (int j = 0; j < 64; j++) begin
               if ((j & step) == 0) begin
                  int idx = 2 * int'(x[j]) + int'(x[j+step]);
                  y[j]      = tb[idx];
                  y[j+step] = tb[4+idx];
               end
            end
            x = y;
         end
      end
      if (nw) x[63:32] = '0;
      return x;
   endfunction

   // Classic swap / or-combine models using masks
   function automatic logic [63:0] classic(input logic [63:0] a, input int sh,
                                          input int nrows, input bit orc);
      logic [63:0] x, m;
      x = a;
      for (int k = 0; k < nrows; k++) begin
         int step = 1 << k;
         if (((sh >> k) & 1) != 0) begin
            for (int j = 0; j < 64; j++) m[j] = ((j & step) == 0);
            if (orc) x = x | ((x & m) << step) | ((x & ~m) >> step);
            else     x = ((x & m) << step) | ((x & ~m) >> step);
         end
      end
      return x;
   endfunction

   function automatic logic [63:0] bitrev(input logic [63:0] a, input int w);
      logic [63:0] r = '0;
      for (int i = 0; i < w; i++) r[i] = a[w-1-i];
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic apply(input bit z, input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] t, input bit iv, input bit nw, input bit pr);
      @(negedge clk);
      in_valid = 1'b1; src_zero = z; src_a = a; src_b = b;
      tbl_imm = t; inv = iv; half_mode = nw; per_row = pr;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run(input string req, input bit z, input logic [63:0] a,
                      input logic [63:0] b, input logic [7:0] t, input bit iv,
                      input bit nw, input bit pr, input logic [63:0] exp);
      apply(z, a, b, t, iv, nw, pr);
      if (out_valid !== 1'b1) begin
         n_checks++; n_fails++;
         $display("FAIL R10: out_valid got %b expected 1", out_valid);
      end
      check(req, out_data, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] a, b, hold_v;
      int unsigned seed_v = 32'd1234;
      void'($urandom(seed_v));
      rst_n = 1'b0; in_valid = 1'b0; src_zero = 1'b0; src_a = '0; src_b = '0;
      tbl_imm = '0; inv = 1'b0; half_mode = 1'b0; per_row = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 reset valid", {63'd0, out_valid}, 64'd0);
      check("R10 reset data", out_data, 64'd0);

      // R9 constants
      run("R9 c1", 1, '0, 64'b10,   8'h6C, 0, 0, 0, 64'h1111_1111_1111_1111);
      run("R9 c2", 1, '0, 64'b110,  8'h6C, 0, 0, 0, 64'h0101_0101_0101_0101);
      run("R9 c3", 1, '0, 64'b1110, 8'h6C, 0, 0, 0, 64'h0001_0001_0001_0001);
      run("R9 c4", 1, '0, 64'b10,   8'hC6, 1, 0, 0, 64'h8888_8888_8888_8888);
      run("R9 c5", 1, '0, 64'b110,  8'hC6, 1, 0, 0, 64'h8080_8080_8080_8080);
      run("R9 c6", 1, '0, 64'b1110, 8'hC6, 1, 0, 0, 64'h8000_8000_8000_8000);

      // R1 / R11 seed pass-through with zero shift
      a = {$urandom, $urandom};
      run("R1 R11 source", 0, a, 64'h0, 8'h5A, 0, 0, 0, a);
      run("R1 R11 constant", 1, a, 64'h0, 8'h5A, 0, 0, 0, 64'h5555_5555_5555_5555);
      // R2 invert
      run("R2 invert src", 0, a, 64'h0, 8'h33, 1, 0, 0, ~a);
      run("R2 invert const", 1, a, 64'h0, 8'h33, 1, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA);

      // R3 nibble split on a single pair
      run("R3 low nibble", 0, 64'h1, 64'h1, 8'h04, 0, 0, 0, 64'h1);
      run("R3 high nibble", 0, 64'h1, 64'h1, 8'h40, 0, 0, 0, 64'h2);
      run("R3 idx0 fill", 0, 64'h0, 64'h1, 8'h11, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);

      // R4 bits above the shift amount are ignored
      a = {$urandom, $urandom};
      run("R4 upper b ignored", 0, a, 64'hFFFF_FFFF_FFFF_FFC0, 8'hCA, 0, 0, 0, a);
      run("R4 row order", 0, a, 64'h2D, 8'h96, 0, 0, 0, spec_model(0, a, 64'h2D, 8'h96, 0, 0, 0));

      // R7 per-row: all rows reverse -> full bit reversal
      a = {$urandom, $urandom};
      run("R7 per-row reverse", 0, a, 64'h0000_CACA_CACA_CACA, 8'h00, 0, 0, 1, bitrev(a, 64));
      run("R7 per-row narrow", 0, a, 64'h0000_00CA_CACA_CACA, 8'hFF, 0, 1, 1,
          {32'd0, bitrev({32'd0, a[31:0]}, 32)[31:0]});

      // R8 narrow mode
      run("R8 step32 absent", 0, a, 64'h20, 8'hCA, 0, 1, 0, {32'd0, a[31:0]});
      run("R8 upper clear", 0, a, 64'h1, 8'hFF, 0, 1, 0, 64'h0000_0000_FFFF_FFFF);

      // R10 hold with no strobe
      hold_v = out_data;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; tbl_imm = 8'h5A;
      end
      check("R10 hold data", out_data, hold_v);
      check("R10 no strobe", {63'd0, out_valid}, 64'd0);

      // R5 / R6 random against classic models
      for (int i = 0; i < 120; i++) begin
         bit nw = ($urandom % 2) != 0;
         int sh;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         sh = nw ? int'(b[4:0]) : int'(b[5:0]);
         if (nw)
            run("R5 grev narrow", 0, a, b, 8'hCA, 0, 1, 0, {32'd0, classic({32'd0, a[31:0]}, sh, 5, 0)[31:0]});
         else
            run("R5 grev wide", 0, a, b, 8'hCA, 0, 0, 0, classic(a, sh, 6, 0));
         if (nw)
            run("R6 gorc narrow", 0, a, b, 8'hEE, 0, 1, 0, {32'd0, classic({32'd0, a[31:0]}, sh, 5, 1)[31:0]});
         else
            run("R6 gorc wide", 0, a, b, 8'hEE, 0, 0, 0, classic(a, sh, 6, 1));
      end

      // Mixed random against the spec model (R3 R4 R7 R8)
      for (int i = 0; i < 300; i++) begin
         bit z  = ($urandom % 4) == 0;
         bit iv = ($urandom % 2) != 0;
         bit nw = ($urandom % 3) == 0;
         bit pr = ($urandom % 2) != 0;
         logic [7:0] t = 8'($urandom);
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         run(pr ? "R7 random" : "R3 R4 random", z, a, b, t, iv, nw, pr,
             spec_model(z, a, b, t, iv, nw, pr));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule